// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block orders the steps of an analog-to-digital converter calibration. A 2-bit calibration code written through a one-cycle write strobe starts a run. The run has one or two measurement phases, zero-scale and/or full-scale. Each phase lasts a fixed number of output-rate periods. The periods are counted from a strobe that the converter's filter delivers once per output word. When the last phase ends, the code readback returns to zero. The block then waits for one settling conversion and a bounded pipeline delay in master-clock cycles. Only after that does it pull the active-low data-ready flag down.

So there are two separate completion points. Software that polls the code readback learns early that the coefficients are in place. A consumer that waits for data-ready knows that a properly scaled conversion result is waiting. A filter-sync hold input freezes the period counting. This lets the host park the filter while it touches other state. The coefficient arithmetic lives elsewhere.

The block has no streaming data path. All pins are plain control and status signals, with no back-pressure.

Top module: `cal_seq`

## Requirements
- R1: After reset the code readback is 00, busy is 0, both phase indicators are 0 and data-ready (active low) is 1.
- R2: A write of a non-zero code while the readback is 00 is accepted. On the next cycle the readback shows the code, busy is 1 and data-ready is 1.
- R3: Code 01 (self-calibration) runs a zero-scale phase for 3 counted periods, then a full-scale phase for 3 counted periods. The readback returns to 00 on the cycle after the 6th counted period strobe.
- R4: Code 10 runs only a zero-scale phase and code 11 runs only a full-scale phase. Each lasts 3 counted periods, and the readback returns to 00 on the cycle after the 3rd.
- R5: After the readback clears, a follow-up conversion lasts 3 counted periods after code 01 and 1 counted period after codes 10 and 11. Data-ready then stays 1 for PIPE_CYCLES master-clock cycles. It goes to 0 on the cycle after that, and busy falls on the same cycle.
- R6: Data-ready is 1 whenever busy is 1.
- R7: A write while the readback is non-zero is ignored. The code and the phase timing continue unchanged.
- R8: A write of code 00 while the readback is 00 has no effect on any output.
- R9: A period strobe that arrives while the filter-sync hold is 1 is not counted.
- R10: A non-zero write during the follow-up conversion or the pipeline delay is accepted. It starts a new run, and data-ready stays 1.
- R11: Once data-ready is 0 and the block is idle, data-ready stays 0 until the next accepted write. Period strobes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | One-cycle write strobe for the calibration code |
| mode_wdata | input | 2 | Calibration code: 00 none, 01 self, 10 system zero-scale, 11 system full-scale |
| period_tick | input | 1 | One-cycle strobe, once per output-rate period |
| sync_hold | input | 1 | Filter-sync hold; 1 pauses period counting |
| mode_bits | output | 2 | Code readback; returns to 00 when calibration phases end |
| zs_active | output | 1 | Zero-scale phase in progress |
| fs_active | output | 1 | Full-scale phase in progress |
| busy | output | 1 | A run (phases, conversion or pipeline delay) is in progress |
| drdy_n | output | 1 | Active-low data-ready |

## Verification
The three codes are each run from start to data-ready. This shows whether the phase order and lengths are right. It also shows whether the short settling (one period) and the long settling (three periods) are correctly split between single-phase and two-phase runs. Strobes with the hold raised, during a phase and during the settling conversion, separate pausing from counting. A write in mid-phase, a write of 00 and a write in the settling window separate the ignored commands from the restarting ones. The pipeline delay is sampled one cycle before and exactly at the edge where data-ready falls.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    CODE_NONE   = 2'b00,
    CODE_SELF   = 2'b01,
    CODE_SYS_ZS = 2'b10,
    CODE_SYS_FS = 2'b11
  } cal_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZERO,
    ST_FULL,
    ST_SETTLE,
    ST_PIPE
  } cal_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cal_mode_reg.sv
module cal_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       clear,
  output logic [1:0] mode,
  output logic       accept
);
  import cal_seq_pkg::*;

  assign accept = wr && (wdata != CODE_NONE) && (mode == CODE_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= CODE_NONE;
    end else if (accept) begin
      mode <= wdata;
    end else if (clear) begin
      mode <= CODE_NONE;
    end
  end
endmodule

// File: rtl/cal_tick_counter.sv
module cal_tick_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = en && (cnt == W'(limit - W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || done) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/cal_cycle_timer.sv
module cal_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned TW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [TW-1:0] cnt;

  assign done = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || done) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + TW'(1);
    end
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int unsigned PHASE_PERIODS  = 3,
  parameter int unsigned SELF_SETTLE    = 3,
  parameter int unsigned SYS_SETTLE     = 1,
  parameter int unsigned PIPE_CYCLES    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       period_tick,
  input  logic       sync_hold,
  output logic [1:0] mode_bits,
  output logic       zs_active,
  output logic       fs_active,
  output logic       busy,
  output logic       drdy_n
);
  import cal_seq_pkg::*;

  localparam int unsigned MAX_PER = max2(PHASE_PERIODS, max2(SELF_SETTLE, SYS_SETTLE));
  localparam int unsigned CW      = $clog2(MAX_PER + 1);

  cal_state_e state_q, state_d;
  logic       self_q;
  logic       accept;
  logic       mode_clear;
  logic       tick_ok;
  logic       count_en;
  logic       per_done;
  logic       pipe_done;
  logic [CW-1:0] per_limit;

  cal_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .clear  (mode_clear),
    .mode   (mode_bits),
    .accept (accept)
  );

  assign tick_ok  = period_tick && !sync_hold;
  assign count_en = tick_ok &&
                    (state_q == ST_ZERO || state_q == ST_FULL || state_q == ST_SETTLE);

  always_comb begin
    if (state_q == ST_SETTLE) begin
      per_limit = self_q ? CW'(SELF_SETTLE) : CW'(SYS_SETTLE);
    end else begin
      per_limit = CW'(PHASE_PERIODS);
    end
  end

  cal_tick_counter #(.W(CW)) u_periods (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (count_en),
    .limit (per_limit),
    .done  (per_done)
  );

  cal_cycle_timer #(.LIMIT(PIPE_CYCLES)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_PIPE),
    .done  (pipe_done)
  );

  always_comb begin
    state_d    = state_q;
    mode_clear = 1'b0;
    if (accept) begin
      state_d = (mode_wdata == CODE_SYS_FS) ? ST_FULL : ST_ZERO;
    end else begin
      unique case (state_q)
        ST_ZERO: begin
          if (per_done) begin
            if (self_q) begin
              state_d = ST_FULL;
            end else begin
              state_d    = ST_SETTLE;
              mode_clear = 1'b1;
            end
          end
        end
        ST_FULL: begin
          if (per_done) begin
            state_d    = ST_SETTLE;
            mode_clear = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (per_done) state_d = ST_PIPE;
        end
        ST_PIPE: begin
          if (pipe_done) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      self_q  <= 1'b0;
      drdy_n  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept) begin
        self_q <= (mode_wdata == CODE_SELF);
        drdy_n <= 1'b1;
      end else if (state_q == ST_PIPE && pipe_done) begin
        drdy_n <= 1'b0;
      end
    end
  end

  assign zs_active = (state_q == ST_ZERO);
  assign fs_active = (state_q == ST_FULL);
  assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr,
  input logic [1:0] mode_wdata,
  input logic       sync_hold,
  input logic [1:0] mode_bits,
  input logic       zs_active,
  input logic       fs_active,
  input logic       busy,
  input logic       drdy_n
);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'b00 && mode_wr && mode_wdata != 2'b00)
      |=> (mode_bits == $past(mode_wdata) && busy && drdy_n));

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(zs_active && fs_active));

  assert_sys_fs_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'b11) |-> !zs_active);

  assert_sys_zs_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'b10) |-> !fs_active);

  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> (!busy && mode_bits == 2'b00));

  assert_busy_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> drdy_n);

  assert_ignore_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits != 2'b00) |=> (mode_bits == $past(mode_bits) || mode_bits == 2'b00));

  assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_wr && mode_wdata == 2'b00) |=> (!busy && mode_bits == 2'b00));

  assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hold && mode_bits != 2'b00) |=> (mode_bits == $past(mode_bits)));

  assert_ready_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !drdy_n && !(mode_wr && mode_wdata != 2'b00)) |=> !drdy_n);

endmodule

bind cal_seq cal_seq_checker u_cal_seq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_wr    (mode_wr),
  .mode_wdata (mode_wdata),
  .sync_hold  (sync_hold),
  .mode_bits  (mode_bits),
  .zs_active  (zs_active),
  .fs_active  (fs_active),
  .busy       (busy),
  .drdy_n     (drdy_n)
);

// File: tb/cal_seq_test.sv
`timescale 1ns/1ps
module cal_seq_test;
  localparam int PIPE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic       period_tick = 1'b0;
  logic       sync_hold = 1'b0;
  logic [1:0] mode_bits;
  logic       zs_active, fs_active, busy, drdy_n;

  int total = 0;
  int bad = 0;

  // {code, zero-scale periods, full-scale periods, settle periods}
  localparam logic [7:0] VEC [3] = '{
    {2'd1, 2'd3, 2'd3, 2'd3},
    {2'd2, 2'd3, 2'd0, 2'd1},
    {2'd3, 2'd0, 2'd3, 2'd1}
  };

  always #10 clk = ~clk;

  cal_seq #(.PIPE_CYCLES(PIPE)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .period_tick(period_tick), .sync_hold(sync_hold), .mode_bits(mode_bits),
    .zs_active(zs_active), .fs_active(fs_active), .busy(busy), .drdy_n(drdy_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_code(logic [1:0] c);
    mode_wr = 1'b1;
    mode_wdata = c;
    @(negedge clk);
    mode_wr = 1'b0;
    mode_wdata = 2'b00;
  endtask

  task automatic tick();
    period_tick = 1'b1;
    @(negedge clk);
    period_tick = 1'b0;
  endtask

  task automatic pipe_wait(string req);
    repeat (PIPE - 1) @(negedge clk);
    check({req, " ready still high before pipeline end"}, drdy_n, 1);
    @(negedge clk);
    check({req, " ready low after pipeline"}, drdy_n, 0);
    check({req, " busy low with ready"}, busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", mode_bits, 0);
    check("R1 busy", busy, 0);
    check("R1 phases", {zs_active, fs_active}, 0);
    check("R1 ready", drdy_n, 1);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[v]) begin
      logic [1:0] c;
      int nz, nf, ns;
      string rq;
      c  = VEC[v][7:6];
      nz = VEC[v][5:4];
      nf = VEC[v][3:2];
      ns = VEC[v][1:0];
      rq = (c == 2'd1) ? "R3" : "R4";
      write_code(c);
      check("R2 mode shows code", mode_bits, c);
      check("R2 busy", busy, 1);
      check("R2 R6 ready high", drdy_n, 1);
      for (int i = 0; i < nz; i++) begin
        check({rq, " zero-scale phase"}, {zs_active, fs_active}, 2'b10);
        check({rq, " code held"}, mode_bits, c);
        tick();
      end
      for (int i = 0; i < nf; i++) begin
        check({rq, " full-scale phase"}, {zs_active, fs_active}, 2'b01);
        check({rq, " code held"}, mode_bits, c);
        tick();
      end
      check({rq, " code cleared"}, mode_bits, 0);
      check({rq, " phases off"}, {zs_active, fs_active}, 0);
      for (int i = 0; i < ns; i++) begin
        check("R5 R6 busy ready high in settle", {busy, drdy_n}, 2'b11);
        tick();
      end
      pipe_wait("R5");
    end

    // R11 ticks in idle keep ready low
    repeat (3) tick();
    check("R11 ready stays low", drdy_n, 0);
    check("R11 busy stays low", busy, 0);

    // R8 write of 00 ignored
    write_code(2'b00);
    check("R8 mode", mode_bits, 0);
    check("R8 busy", busy, 0);
    check("R8 ready", drdy_n, 0);

    // R7 write during calibration ignored
    write_code(2'b01);
    tick();
    tick();
    write_code(2'b10);
    check("R7 code unchanged", mode_bits, 1);
    tick();
    check("R7 moved to full-scale on schedule", {zs_active, fs_active}, 2'b01);
    tick();
    tick();
    check("R7 code still set before 6th", mode_bits, 1);
    tick();
    check("R7 code clears after 6 total", mode_bits, 0);

    // R9 hold during settle
    sync_hold = 1'b1;
    repeat (5) tick();
    check("R9 held settle keeps busy", busy, 1);
    sync_hold = 1'b0;
    repeat (3) tick();
    pipe_wait("R9");

    // R9 hold during phase
    write_code(2'b11);
    sync_hold = 1'b1;
    repeat (4) tick();
    check("R9 held phase keeps code", mode_bits, 3);
    sync_hold = 1'b0;
    tick();
    tick();
    check("R9 code before 3rd counted", mode_bits, 3);
    tick();
    check("R9 code cleared after 3 counted", mode_bits, 0);

    // R10 write during settle restarts
    write_code(2'b10);
    check("R10 restart code", mode_bits, 2);
    check("R10 restart phase", {zs_active, fs_active}, 2'b10);
    check("R10 ready high", drdy_n, 1);
    repeat (3) tick();
    check("R10 code cleared", mode_bits, 0);
    tick();
    repeat (5) @(negedge clk);
    // R10 write during pipeline delay restarts
    write_code(2'b11);
    check("R10 restart in pipe", {mode_bits, fs_active}, 3'b111);
    repeat (3) tick();
    tick();
    pipe_wait("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule